// File: doc/BRIEF.md
# Timer Capture and Compare Unit

A 16-bit timer counts up by one per clock while its run bit is set. Four capture channels watch input pins. On an enabled edge, a channel copies the current count into its own register and raises its own flag. Each channel selects rising edges, falling edges, or both.

Three compare registers are checked against the count on every clock. When the count equals a compare value:
- that compare's match flag is raised;
- six set/reset pins, two per compare register, are driven high or low according to their enable bits;
- two toggle pins invert their flip-flop state.

Software drives everything through a single write port. Flags are cleared by writing ones to a clear register. The count, the capture values, the flags and the pins are all visible as outputs.

Top module: `tcc_unit`

## Requirements
- R1: After reset, the count, all capture values, all flags, the set/reset pins and the toggle pins are zero.
- R2: A write to address 0 loads the count. While bit 0 of address 1 (run) is 1, the count rises by exactly one per clock. While run is 0, the count holds.
- R3: The overflow flag `ovf_o` is set when a running count rolls over from FFFFh to 0000h. Writing 1 to bit 7 of address 10 clears it.
- R4: Address 9 holds the capture edge enables. For channel k, bit 2k enables rising edges and bit 2k+1 enables falling edges. Both may be set together. A channel with neither bit set never loads its register.
- R5: Each capture pin passes through a two-flop synchronizer. With the timer running, the captured value equals the count visible in the cycle in which the pin changed, plus 2.
- R6: A capture raises bit k of `cap_flag_o`. Writing 1 to bit k of address 10 clears that flag.
- R7: When a capture and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R8: Compare values are written at addresses 2, 3 and 4. While running, a count equal to compare value c sets bit c of `match_flag_o`. Writing 1 to bit 4+c of address 10 clears that flag.
- R9: Set/reset pin i is tied to compare value i/2. On a match, pin i goes high if bit i of address 5 (set enable) is 1. It goes low if bit i of address 6 (reset enable) is 1. Reset wins when both are set.
- R10: Toggle pin j is tied to compare value j. `tog_o[j]` equals its flip-flop bit, which is loaded by writing bit j of address 8. The flip-flop inverts on a match when bit j of address 7 (toggle enable) is 1.
- R11: While the timer is halted, a count equal to a compare value produces no match: pins and match flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 16 | Register write data |
| cap_pin_i | input | 4 | Capture trigger pins |
| cnt_o | output | 16 | Current timer count |
| ovf_o | output | 1 | Timer overflow flag |
| cap_val_o | output | 64 | Capture registers, channel k at bits 16k+15:16k |
| cap_flag_o | output | 4 | Capture flags |
| match_flag_o | output | 3 | Compare match flags |
| sr_o | output | 6 | Set/reset output pins |
| tog_o | output | 2 | Toggle output pins |

## Verification
The assertions assume the following about the inputs:
- capture pins are held for at least three clocks between changes, so that every change is seen by the synchronizer;
- the run bit and the count are not rewritten in the cycle a property is watching.

The stimulus changes pins only at falling clock edges and holds each level for several cycles. Captures that must have an exact value are taken with the timer halted, except in the single latency case. Compare passes are bounded so that the count never wraps during them.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int TW    = 16;
  localparam int N_CAP = 4;
  localparam int N_CMP = 3;
  localparam int N_SR  = 6;
  localparam int N_TOG = 2;
  localparam int AW    = 4;

  localparam int A_CNT  = 0;
  localparam int A_RUN  = 1;
  localparam int A_CMP  = 2;
  localparam int A_SET  = A_CMP + N_CMP;
  localparam int A_RST  = A_SET + 1;
  localparam int A_TGE  = A_RST + 1;
  localparam int A_TGF  = A_TGE + 1;
  localparam int A_EDGE = A_TGF + 1;
  localparam int A_CLR  = A_EDGE + 1;

  localparam int CLR_OVF = N_CAP + N_CMP;
endpackage

// File: rtl/tcc_timer.sv
module tcc_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          ld_i,
  input  logic [TW-1:0] ld_val_i,
  input  logic          ovf_clr_i,
  output logic [TW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [TW-1:0] cnt_q;
  logic          ovf_q;
  logic          wrap;

  assign wrap = run_i && !ld_i && (cnt_q == {TW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_i) begin
      cnt_q <= ld_val_i;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
    end else if (wrap) begin
      ovf_q <= 1'b1;
    end else if (ovf_clr_i) begin
      ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !ld_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
  a_r2_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_i) |=> $stable(cnt_o));
  a_r3_overflow_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !ld_i && cnt_o == {TW{1'b1}}) |=> (ovf_o && cnt_o == '0));
endmodule

// File: rtl/tcc_cap_chan.sv
module tcc_cap_chan #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_i,
  input  logic          rise_en_i,
  input  logic          fall_en_i,
  input  logic [TW-1:0] cnt_i,
  input  logic          clr_i,
  output logic [TW-1:0] cap_o,
  output logic          flag_o
);
  logic s1_q, s2_q, s3_q;
  logic hit;
  logic [TW-1:0] cap_q;
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign hit = (rise_en_i && s2_q && !s3_q) || (fall_en_i && !s2_q && s3_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
    end else if (hit) begin
      cap_q <= cnt_i;
    end
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (hit) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  a_r5_capture_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (cap_o == $past(cnt_i)));
  a_r4_no_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_en_i && !fall_en_i) |=> $stable(cap_o));
  a_r7_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && clr_i) |=> flag_o);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !flag_o);
endmodule

// File: rtl/tcc_cmp_chan.sv
module tcc_cmp_chan #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] cnt_i,
  input  logic [TW-1:0] cmp_i,
  input  logic          clr_i,
  output logic          hit_o,
  output logic          flag_o
);
  logic flag_q;

  assign hit_o = run_i && (cnt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (hit_o) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  a_r8_match_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == cmp_i) |=> flag_o);
  a_r11_halted_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/tcc_pin_out.sv
module tcc_pin_out #(
  parameter int N_CMP = 3,
  parameter int N_SR  = 6,
  parameter int N_TOG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CMP-1:0] hit_i,
  input  logic [N_SR-1:0]  set_en_i,
  input  logic [N_SR-1:0]  rst_en_i,
  input  logic [N_TOG-1:0] tog_en_i,
  input  logic             tog_wr_i,
  input  logic [N_TOG-1:0] tog_wdata_i,
  output logic [N_SR-1:0]  sr_o,
  output logic [N_TOG-1:0] tog_o
);
  localparam int SR_PER = N_SR / N_CMP;

  for (genvar i = 0; i < N_SR; i++) begin : g_sr
    localparam int C = i / SR_PER;
    logic pin_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pin_q <= 1'b0;
      end else if (hit_i[C] && rst_en_i[i]) begin
        pin_q <= 1'b0;
      end else if (hit_i[C] && set_en_i[i]) begin
        pin_q <= 1'b1;
      end
    end

    assign sr_o[i] = pin_q;

    a_r9_reset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i[C] && rst_en_i[i]) |=> !sr_o[i]);
    a_r9_set_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i[C] && set_en_i[i] && !rst_en_i[i]) |=> sr_o[i]);
  end

  for (genvar j = 0; j < N_TOG; j++) begin : g_tog
    logic ff_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff_q <= 1'b0;
      end else if (tog_wr_i) begin
        ff_q <= tog_wdata_i[j];
      end else if (hit_i[j] && tog_en_i[j]) begin
        ff_q <= ~ff_q;
      end
    end

    assign tog_o[j] = ff_q;

    a_r10_toggle_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i[j] && tog_en_i[j] && !tog_wr_i) |=> (tog_o[j] != $past(tog_o[j])));
  end
endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
  import tcc_pkg::*;
#(
  parameter int P_TW    = TW,
  parameter int P_N_CAP = N_CAP,
  parameter int P_N_CMP = N_CMP,
  parameter int P_N_SR  = N_SR,
  parameter int P_N_TOG = N_TOG,
  parameter int P_AW    = AW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [P_AW-1:0]          wr_addr_i,
  input  logic [P_TW-1:0]          wr_data_i,
  input  logic [P_N_CAP-1:0]       cap_pin_i,
  output logic [P_TW-1:0]          cnt_o,
  output logic                     ovf_o,
  output logic [P_N_CAP*P_TW-1:0]  cap_val_o,
  output logic [P_N_CAP-1:0]       cap_flag_o,
  output logic [P_N_CMP-1:0]       match_flag_o,
  output logic [P_N_SR-1:0]        sr_o,
  output logic [P_N_TOG-1:0]       tog_o
);
  localparam int NCLR = P_N_CAP + P_N_CMP + 1;

  logic                           run_q;
  logic [P_N_CMP-1:0][P_TW-1:0]   cmp_q;
  logic [P_N_SR-1:0]              set_en_q, rst_en_q;
  logic [P_N_TOG-1:0]             tog_en_q;
  logic [2*P_N_CAP-1:0]           edge_en_q;
  logic [NCLR-1:0]                clr;
  logic [P_N_CMP-1:0]             hit;

  function automatic logic wr_at(input int a);
    return wr_en_i && (wr_addr_i == P_AW'(a));
  endfunction

  assign clr = wr_at(A_CLR) ? wr_data_i[NCLR-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      set_en_q  <= '0;
      rst_en_q  <= '0;
      tog_en_q  <= '0;
      edge_en_q <= '0;
    end else begin
      if (wr_at(A_RUN))  run_q     <= wr_data_i[0];
      if (wr_at(A_SET))  set_en_q  <= wr_data_i[P_N_SR-1:0];
      if (wr_at(A_RST))  rst_en_q  <= wr_data_i[P_N_SR-1:0];
      if (wr_at(A_TGE))  tog_en_q  <= wr_data_i[P_N_TOG-1:0];
      if (wr_at(A_EDGE)) edge_en_q <= wr_data_i[2*P_N_CAP-1:0];
    end
  end

  for (genvar c = 0; c < P_N_CMP; c++) begin : g_cmp_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q[c] <= '0;
      end else if (wr_at(A_CMP + c)) begin
        cmp_q[c] <= wr_data_i;
      end
    end
  end

  tcc_timer #(.TW(P_TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .ld_i      (wr_at(A_CNT)),
    .ld_val_i  (wr_data_i),
    .ovf_clr_i (clr[NCLR-1]),
    .cnt_o     (cnt_o),
    .ovf_o     (ovf_o)
  );

  for (genvar k = 0; k < P_N_CAP; k++) begin : g_cap
    tcc_cap_chan #(.TW(P_TW)) u_cap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (cap_pin_i[k]),
      .rise_en_i (edge_en_q[2*k]),
      .fall_en_i (edge_en_q[2*k+1]),
      .cnt_i     (cnt_o),
      .clr_i     (clr[k]),
      .cap_o     (cap_val_o[k*P_TW +: P_TW]),
      .flag_o    (cap_flag_o[k])
    );
  end

  for (genvar c = 0; c < P_N_CMP; c++) begin : g_cmp
    tcc_cmp_chan #(.TW(P_TW)) u_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_q),
      .cnt_i  (cnt_o),
      .cmp_i  (cmp_q[c]),
      .clr_i  (clr[P_N_CAP + c]),
      .hit_o  (hit[c]),
      .flag_o (match_flag_o[c])
    );
  end

  tcc_pin_out #(.N_CMP(P_N_CMP), .N_SR(P_N_SR), .N_TOG(P_N_TOG)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .set_en_i    (set_en_q),
    .rst_en_i    (rst_en_q),
    .tog_en_i    (tog_en_q),
    .tog_wr_i    (wr_at(A_TGF)),
    .tog_wdata_i (wr_data_i[P_N_TOG-1:0]),
    .sr_o        (sr_o),
    .tog_o       (tog_o)
  );

  a_r11_halted_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_at(A_TGF)) |=> ($stable(sr_o) && $stable(tog_o)));
endmodule

// File: tb/tcc_unit_bench.sv
module tcc_unit_bench;
  import tcc_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [3:0]    cap_pin = '0;
  logic [15:0]   cnt;
  logic          ovf;
  logic [63:0]   cap_val;
  logic [3:0]    cap_flag;
  logic [2:0]    match_flag;
  logic [5:0]    sr;
  logic [1:0]    tog;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcc_unit u_tcc_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cap_pin_i(cap_pin), .cnt_o(cnt), .ovf_o(ovf),
    .cap_val_o(cap_val), .cap_flag_o(cap_flag), .match_flag_o(match_flag),
    .sr_o(sr), .tog_o(tog)
  );

  typedef struct {
    string       req;
    int          kind;
    logic [15:0] exp;
  } item_t;

  localparam int K_CNT = 0, K_SR = 1, K_TOG = 2, K_CFLAG = 3, K_MFLAG = 4, K_OVF = 5, K_CAP = 10;

  item_t q[$];
  event  chk_ev;
  int    nchk = 0;
  int    nfail = 0;
  bit    done = 1'b0;

  function automatic logic [15:0] obs(input int k);
    case (k)
      K_CNT:   return cnt;
      K_SR:    return {10'd0, sr};
      K_TOG:   return {14'd0, tog};
      K_CFLAG: return {12'd0, cap_flag};
      K_MFLAG: return {13'd0, match_flag};
      K_OVF:   return {15'd0, ovf};
      default: return cap_val[(k-K_CAP)*16 +: 16];
    endcase
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() != 0) begin
        item_t it;
        logic [15:0] got;
        it = q.pop_front();
        got = obs(it.kind);
        nchk++;
        if (got !== it.exp) begin
          nfail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input string r, input int k, input logic [15:0] e);
    q.push_back('{r, k, e});
    -> chk_ev;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_span(input logic [15:0] start, input int n);
    wr(A_RUN, 16'd0);
    wr(A_CNT, start);
    wr(A_RUN, 16'd1);
    idle(n);
    wr(A_RUN, 16'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_val("R1", K_CNT, 16'h0);
    expect_val("R1", K_SR, 16'h0);
    expect_val("R1", K_TOG, 16'h0);
    expect_val("R1", K_CFLAG, 16'h0);
    expect_val("R1", K_MFLAG, 16'h0);
    expect_val("R1", K_OVF, 16'h0);
    expect_val("R1", K_CAP + 0, 16'h0);

    // R2 load, count, hold
    wr(A_CNT, 16'h1234);
    expect_val("R2 load", K_CNT, 16'h1234);
    wr(A_RUN, 16'd1);
    a = cnt;
    idle(7);
    expect_val("R2 step", K_CNT, a + 16'd7);
    wr(A_RUN, 16'd0);
    a = cnt;
    idle(5);
    expect_val("R2 hold", K_CNT, a);

    // R3 overflow
    run_span(16'hFFFD, 6);
    expect_val("R3 set", K_OVF, 16'd1);
    wr(A_CLR, 16'h0080);
    expect_val("R3 clear", K_OVF, 16'd0);

    // R4/R6 captures with halted timer: ch0 rise, ch1 fall, ch2 both, ch3 none
    wr(A_CNT, 16'h1234);
    wr(A_EDGE, 16'h0039);
    cap_pin = 4'hF;
    idle(5);
    expect_val("R4 ch0 rise", K_CAP + 0, 16'h1234);
    expect_val("R4 ch1 no rise", K_CAP + 1, 16'h0000);
    expect_val("R4 ch2 rise", K_CAP + 2, 16'h1234);
    expect_val("R4 ch3 off", K_CAP + 3, 16'h0000);
    expect_val("R6 flags", K_CFLAG, 16'h0005);
    wr(A_CNT, 16'h5678);
    cap_pin = 4'h0;
    idle(5);
    expect_val("R4 ch0 no fall", K_CAP + 0, 16'h1234);
    expect_val("R4 ch1 fall", K_CAP + 1, 16'h5678);
    expect_val("R4 ch2 fall", K_CAP + 2, 16'h5678);
    expect_val("R4 ch3 off", K_CAP + 3, 16'h0000);
    expect_val("R6 flags", K_CFLAG, 16'h0007);
    wr(A_CLR, 16'h000F);
    expect_val("R6 clear", K_CFLAG, 16'h0000);

    // R5 latency with running timer
    wr(A_CNT, 16'h0100);
    wr(A_RUN, 16'd1);
    idle(2);
    v = cnt;
    cap_pin[0] = 1'b1;
    idle(6);
    wr(A_RUN, 16'd0);
    expect_val("R5 latency", K_CAP + 0, v + 16'd2);
    wr(A_CLR, 16'h000F);

    // R7 capture and clear collide
    cap_pin[0] = 1'b0;
    idle(5);
    expect_val("R7 pre", K_CFLAG, 16'h0000);
    cap_pin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(A_CLR); wr_data = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0;
    idle(1);
    expect_val("R7 set wins", K_CFLAG, 16'h0001);

    // R8/R9/R10 compare pass
    wr(A_CLR, 16'h00FF);
    wr(A_CMP + 0, 16'd10);
    wr(A_CMP + 1, 16'd20);
    wr(A_CMP + 2, 16'd1000);
    wr(A_SET, 16'h0007);
    wr(A_RST, 16'h0002);
    wr(A_TGE, 16'h0001);
    wr(A_TGF, 16'h0002);
    expect_val("R10 ff write", K_TOG, 16'h0002);
    run_span(16'd5, 30);
    expect_val("R8 flags", K_MFLAG, 16'h0003);
    expect_val("R9 set and reset wins", K_SR, 16'h0005);
    expect_val("R10 toggle", K_TOG, 16'h0003);
    wr(A_CLR, 16'h0070);
    expect_val("R8 clear", K_MFLAG, 16'h0000);

    // R9 reset pass, R10 second toggle
    wr(A_SET, 16'h0000);
    wr(A_RST, 16'h0001);
    run_span(16'd5, 30);
    expect_val("R9 reset", K_SR, 16'h0004);
    expect_val("R10 toggle back", K_TOG, 16'h0002);

    // R11 halted timer sitting on a compare value
    wr(A_CLR, 16'h0070);
    wr(A_SET, 16'h0008);
    wr(A_TGE, 16'h0002);
    wr(A_CNT, 16'd20);
    idle(5);
    expect_val("R11 pins", K_SR, 16'h0004);
    expect_val("R11 tog", K_TOG, 16'h0002);
    expect_val("R11 flags", K_MFLAG, 16'h0000);

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule